// File: doc/BRIEF.md
# Single-Error-Correcting Hamming Decoder with Data Extraction

This block takes a 30-bit Hamming codeword, with check bits at the power-of-two positions, and recovers the 25-bit payload in one registered pass. It builds a 5-bit syndrome from the received word. A non-zero syndrome within the word names the 1-based position of the flipped bit, and the decoder inverts that bit. The decoder then gathers the payload bits from the remaining positions and presents them at the output.

A mode input selects the parity sense used when the word was built. In even mode every check group XORs to zero on a clean word. In odd mode every check group XORs to one on a clean word, and the decoder inverts each syndrome bit so that a clean word still gives zero. A syndrome that points past position 30 cannot come from a single flip. The decoder raises a separate flag for it and leaves the word as received.

Results appear one clock after a valid input, together with a one-cycle valid strobe. Between strobes they hold their last values.

Top module: `hsec_decoder`

## Requirements
- R1: While rst_ni is low and after its release, before any valid input: valid_o, data_o, syndrome_o, corrected_o and uncorrectable_o are all zero.
- R2: valid_o is high in the cycle after a cycle in which valid_i is high, and low in every other cycle.
- R3: In even mode (odd_mode_i = 0), syndrome bit k is the XOR of every code_i position p (1..30, held in code_i[p-1]) whose index has bit k set. A single flip at position p of a clean word therefore gives syndrome p, and a flip at position 25 gives 5'b11001.
- R4: In odd mode (odd_mode_i = 1), every syndrome bit is the inverse of the even-mode value. A clean odd-parity word gives syndrome zero, and a single flip at position p gives syndrome p.
- R5: A zero syndrome leaves the word unchanged, with corrected_o = 0 and uncorrectable_o = 0.
- R6: A syndrome s in 1..30 inverts position s before extraction and sets corrected_o = 1 and uncorrectable_o = 0, so any single flip of a clean word returns the original payload.
- R7: A syndrome above 30 (the value 31) sets uncorrectable_o = 1 and corrected_o = 0. The payload is extracted from the word exactly as received.
- R8: data_o[j] takes the j-th position, counting from 0 in ascending order, that is not a power of two. data_o[0] comes from position 3 and data_o[24] from position 30.
- R9: When valid_i is low, data_o, syndrome_o, corrected_o and uncorrectable_o keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Codeword and mode are valid this cycle |
| odd_mode_i | input | 1 | 1: odd-parity check groups, 0: even |
| code_i | input | 30 | Received codeword, position p in bit p-1 |
| valid_o | output | 1 | Registered results are fresh this cycle |
| data_o | output | 25 | Recovered payload |
| syndrome_o | output | 5 | Computed syndrome |
| corrected_o | output | 1 | A bit inside the word was inverted |
| uncorrectable_o | output | 1 | Syndrome points past the last position |

## Verification
The assertions assume that valid_i stays low through reset and that code_i and odd_mode_i are known whenever valid_i is high. They also assume that the result registers change only on a valid cycle, which is what lets the hold and strobe properties stand. The stimulus drives every input on the falling clock edge, raises valid_i for exactly one cycle per word, and keeps valid_i low through reset. Multi-bit corruption is injected only as pairs whose position XOR is 31, which places the decoder in its out-of-range case and never in silent miscorrection.

// File: rtl/hsec_pkg.sv
package hsec_pkg;
  // Position (1-based) of the j-th non-power-of-two slot, ascending.
  function automatic int data_pos(input int j);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p < 4096; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (cnt == j && res == 0) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic int par_bits(input int data_w);
    int r;
    r = 1;
    while ((1 << r) < data_w + r + 1) r++;
    return r;
  endfunction
endpackage

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
  parameter int CODE_W = 30,
  parameter int PAR_W  = 5
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              odd_i,
  output logic [PAR_W-1:0]  syn_o
);
  function automatic logic [CODE_W-1:0] grp_mask(input int k);
    logic [CODE_W-1:0] m;
    m = '0;
    for (int p = 1; p <= CODE_W; p++)
      if (p[k]) m[p-1] = 1'b1;
    return m;
  endfunction

  for (genvar k = 0; k < PAR_W; k++) begin : g_bit
    localparam logic [CODE_W-1:0] MASK = grp_mask(k);
    assign syn_o[k] = (^(code_i & MASK)) ^ odd_i;
  end
endmodule

// File: rtl/hsec_correct.sv
module hsec_correct #(
  parameter int CODE_W = 30,
  parameter int PAR_W  = 5
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic [PAR_W-1:0]  syn_i,
  output logic [CODE_W-1:0] fixed_o,
  output logic              hit_o,
  output logic              over_o
);
  localparam logic [PAR_W-1:0] LAST = PAR_W'(CODE_W);

  for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
    localparam logic [PAR_W-1:0] POS = PAR_W'(p);
    assign fixed_o[p-1] = code_i[p-1] ^ (syn_i == POS);
  end

  assign over_o = syn_i > LAST;
  assign hit_o  = (syn_i != '0) && !over_o;
endmodule

// File: rtl/hsec_extract.sv
module hsec_extract #(
  parameter int DATA_W = 25,
  parameter int CODE_W = 30
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [DATA_W-1:0] data_o
);
  for (genvar j = 0; j < DATA_W; j++) begin : g_dat
    localparam int POS = hsec_pkg::data_pos(j);
    assign data_o[j] = code_i[POS-1];
  end
endmodule

// File: rtl/hsec_decoder.sv
module hsec_decoder #(
  parameter int DATA_W = 25,
  parameter int PAR_W  = hsec_pkg::par_bits(DATA_W),
  parameter int CODE_W = DATA_W + PAR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              odd_mode_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [PAR_W-1:0]  syndrome_o,
  output logic              corrected_o,
  output logic              uncorrectable_o
);
  logic [PAR_W-1:0]  syn;
  logic [CODE_W-1:0] fixed;
  logic [DATA_W-1:0] payload;
  logic              hit, over;

  hsec_syndrome #(.CODE_W(CODE_W), .PAR_W(PAR_W)) u_syn (
    .code_i (code_i),
    .odd_i  (odd_mode_i),
    .syn_o  (syn)
  );

  hsec_correct #(.CODE_W(CODE_W), .PAR_W(PAR_W)) u_fix (
    .code_i  (code_i),
    .syn_i   (syn),
    .fixed_o (fixed),
    .hit_o   (hit),
    .over_o  (over)
  );

  hsec_extract #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_ext (
    .code_i (fixed),
    .data_o (payload)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o         <= 1'b0;
      data_o          <= '0;
      syndrome_o      <= '0;
      corrected_o     <= 1'b0;
      uncorrectable_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o          <= payload;
        syndrome_o      <= syn;
        corrected_o     <= hit;
        uncorrectable_o <= over;
      end
    end
  end
endmodule

// File: rtl/hsec_decoder_chk.sv
module hsec_decoder_chk #(
  parameter int DATA_W = 25,
  parameter int PAR_W  = 5,
  parameter int CODE_W = 30
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] data_o,
  input logic [PAR_W-1:0]  syndrome_o,
  input logic              corrected_o,
  input logic              uncorrectable_o
);
  localparam logic [PAR_W-1:0] LAST = PAR_W'(CODE_W);

  p_strobe_on_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_strobe_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_clean_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && syndrome_o == '0) |-> (!corrected_o && !uncorrectable_o));
  p_fix_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && syndrome_o != '0 && syndrome_o <= LAST) |-> (corrected_o && !uncorrectable_o));
  p_beyond_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && syndrome_o > LAST) |-> (uncorrectable_o && !corrected_o));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(data_o) && $stable(syndrome_o) &&
                  $stable(corrected_o) && $stable(uncorrectable_o)));
endmodule

bind hsec_decoder hsec_decoder_chk #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .valid_i         (valid_i),
  .valid_o         (valid_o),
  .data_o          (data_o),
  .syndrome_o      (syndrome_o),
  .corrected_o     (corrected_o),
  .uncorrectable_o (uncorrectable_o)
);

// File: tb/hsec_decoder_tb.sv
`timescale 1ns/1ps
module hsec_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld_i = 1'b0;
  logic        odd = 1'b0;
  logic [29:0] code = '0;
  logic        vld_o;
  logic [24:0] dat;
  logic [4:0]  syn;
  logic        cor, unc;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  hsec_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld_i), .odd_mode_i(odd), .code_i(code),
    .valid_o(vld_o), .data_o(dat), .syndrome_o(syn),
    .corrected_o(cor), .uncorrectable_o(unc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] encode(input logic [24:0] d, input bit o);
    logic [29:0] c;
    int j;
    bit par;
    c = '0;
    j = 0;
    for (int p = 1; p <= 30; p++)
      if ((p & (p - 1)) != 0) begin c[p-1] = d[j]; j++; end
    for (int k = 0; k < 5; k++) begin
      par = o;
      for (int p = 1; p <= 30; p++)
        if (((p >> k) & 1) == 1 && p != (1 << k)) par ^= c[p-1];
      c[(1 << k) - 1] = par;
    end
    return c;
  endfunction

  // one valid word; outputs sampled on the following falling edge
  task automatic apply(input logic [29:0] c, input bit o);
    @(negedge clk);
    code = c; odd = o; vld_i = 1'b1;
    @(negedge clk);
    vld_i = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 valid", {31'd0, vld_o}, 0);
    chk("R1 data", {7'd0, dat}, 0);
    chk("R1 flags", {25'd0, syn, cor, unc}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 after release", {7'd0, dat} | {27'd0, syn} | {31'd0, vld_o | cor | unc}, 0);
  endtask

  task automatic t_latency;
    apply(encode(25'h0ABCDE, 0), 0);
    chk("R2 strobe high", {31'd0, vld_o}, 1);
    @(negedge clk);
    chk("R2 strobe low", {31'd0, vld_o}, 0);
  endtask

  task automatic t_clean;
    logic [24:0] pats [4];
    pats[0] = 25'h0000000; pats[1] = 25'h1FFFFFF;
    pats[2] = 25'h17EE656; pats[3] = 25'h0AAAAAA;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 4; i++) begin
        apply(encode(pats[i], m[0]), m[0]);
        chk(m ? "R4 clean syndrome" : "R3 clean syndrome", {27'd0, syn}, 0);
        chk("R5 clean data", {7'd0, dat}, {7'd0, pats[i]});
        chk("R5 clean flags", {30'd0, cor, unc}, 0);
      end
  endtask

  task automatic t_single;
    logic [24:0] d;
    logic [29:0] c;
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 2; v++) begin
        d = v ? 25'h17EE656 : 25'h1530F9C;
        c = encode(d, m[0]);
        for (int p = 1; p <= 30; p++) begin
          apply(c ^ (30'd1 << (p - 1)), m[0]);
          chk(m ? "R4 syndrome" : "R3 syndrome", {27'd0, syn}, p);
          chk("R6 data", {7'd0, dat}, {7'd0, d});
          chk("R6 flags", {30'd0, cor, unc}, 2);
        end
      end
    apply(encode(25'h17EE656, 0) ^ (30'd1 << 24), 0);
    chk("R3 position 25", {27'd0, syn}, {27'd0, 5'b11001});
  endtask

  task automatic t_beyond;
    logic [29:0] c;
    for (int m = 0; m < 2; m++) begin
      c = encode(25'h0F0F0F0, m[0]);
      apply(c ^ 30'h20000001, m[0]);
      chk("R7 syndrome", {27'd0, syn}, 31);
      chk("R7 flags", {30'd0, cor, unc}, 1);
      chk("R7 R8 raw data, top bit from position 30", {7'd0, dat}, {7'd0, 25'h0F0F0F0 ^ 25'h1000000});
    end
  endtask

  task automatic t_mapping;
    logic [29:0] c;
    c = '0;
    c[2] = 1'b1; c[29] = 1'b1;
    c = encode(25'h1000001, 0);
    apply(c, 0);
    chk("R8 ends", {7'd0, dat}, {7'd0, 25'h1000001});
    for (int j = 0; j < 25; j++) begin
      apply(encode(25'd1 << j, 1), 1);
      chk("R8 one-hot", {7'd0, dat}, {7'd0, 25'd1 << j});
    end
  endtask

  task automatic t_hold;
    apply(encode(25'h1234567, 0) ^ 30'h100, 0);
    @(negedge clk);
    code = 30'h3FFFFFFF; odd = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 data held", {7'd0, dat}, {7'd0, 25'h1234567});
    chk("R9 syndrome held", {27'd0, syn}, 9);
    chk("R9 flags held", {30'd0, cor, unc}, 2);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_clean();
    t_single();
    t_beyond();
    t_mapping();
    t_hold();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule